// File: doc/BRIEF.md
# Burst Carrier Phase and Frequency Tracker

This block cleans up the residual carrier error in one received burst of symbol-rate phase samples and turns the samples into data dibits. Each sample is an 8-bit absolute phase, where 256 counts make a full turn. A second-order tracking loop follows both the phase and the frequency of the carrier. It is seeded with a coarse frequency estimate that comes from an earlier estimation stage. The loop gains are plain arithmetic shifts, and the phase error is folded into one quadrant so that it measures the distance to the nearest constellation point.

The loop has not settled during the opening part of the burst. Those samples are therefore kept in a small store. The loop runs forward through the whole burst. It then turns around and runs backward over the stored opening samples, carrying its settled state with the frequency sign reversed. The backward decisions replace the early forward ones. All decisions go into a reorder store and are read out in arrival order through a differential decoder. A single pulse marks the end of the burst.

Top module: `cr_carrier_track`

## Requirements
- R1: After reset, and whenever no burst has been started, `dibit_valid` and `burst_done` stay low, and `sym_valid` pulses have no effect.
- R2: A `start` pulse begins a new burst in any state and abandons the burst in progress. The phase state is cleared to zero and the frequency state is loaded from `freq_init`. A sample presented with `sym_valid` in the same cycle as `start` is taken as sample 0 of the new burst.
- R3: Samples with an odd index inside the burst have 32 counts added before any other processing. Samples with an even index are used unchanged.
- R4: The loop keeps 12-bit phase and frequency states. Each carries 4 fraction bits below the 8-bit phase count, and `freq_init` uses the same two's-complement format. For a sample y, the error e is the low 6 bits of (y − integer phase), read as signed (−32..31). The loop then updates frequency += e and phase += new frequency + 8·e, both in fraction units.
- R5: The quadrant decided for a sample is bits [7:6] of (y − integer phase + 32). The integer phase used is the one held before that sample's update.
- R6: After sample 59 is taken, the frequency state is negated. Samples 29 down to 0 are then reprocessed, one per cycle, from the stored copies. Their new quadrants replace the ones decided in the forward pass.
- R7: Exactly 60 dibits are then produced on consecutive cycles, in sample order. The first appears 30 clock edges after the edge that accepts sample 59.
- R8: Each dibit is derived from the quadrant change Δ = (q[k] − q[k−1]) mod 4, with q[−1] = 0. The mapping is Δ=0 to 00, Δ=1 to 01, Δ=2 to 11 and Δ=3 to 10.
- R9: `burst_done` is high for exactly one cycle, namely the cycle right after the last dibit.
- R10: `sym_valid` pulses that arrive while the backward pass or the readout is running have no effect on the dibits produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a burst and reseeds the loop |
| freq_init | input | 12 | Coarse frequency seed, two's complement, 4 fraction bits |
| sym_valid | input | 1 | Qualifies `sym_phase` |
| sym_phase | input | 8 | Absolute phase sample, 256 counts per turn |
| dibit_valid | output | 1 | Qualifies `dibit` |
| dibit | output | 2 | Decoded data dibit |
| burst_done | output | 1 | One-cycle end-of-burst marker |

## Verification
Two events can fall in the same cycle: reseeding the loop on `start`, and updating it with an accepted sample. The bench provokes this by aborting a half-received burst with a `start` that carries sample 0 of a new burst in the same cycle. The result is judged by the single completion that follows, whose 60 dibits must match an arithmetic model that treats that sample as index 0 with the fresh seed. Further bursts sweep the phase offset, the frequency offset, mismatched seeds, input gaps and stray samples during the readout.

// File: rtl/cr_pkg.sv
package cr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD,
        ST_BACK,
        ST_OUT,
        ST_DONE
    } trk_state_e;

    typedef logic [1:0] quad_t;

    typedef struct packed {
        logic  valid;
        quad_t dibit;
        logic  done;
    } out_beat_t;

    // Gray mapping of a quadrant step onto a dibit
    function automatic quad_t step_to_dibit(quad_t dq);
        case (dq)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            2'd2:    return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/cr_loop_core.sv
module cr_loop_core
    import cr_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int FRAC_W  = 4,
    parameter int KA      = 1,
    parameter int KB      = 4
) (
    input  logic signed [PHASE_W+FRAC_W-1:0] phase_i,
    input  logic signed [PHASE_W+FRAC_W-1:0] freq_i,
    input  logic        [PHASE_W-1:0]        samp_i,
    input  logic                             odd_i,
    output logic signed [PHASE_W+FRAC_W-1:0] phase_o,
    output logic signed [PHASE_W+FRAC_W-1:0] freq_o,
    output quad_t                            quad_o
);
    localparam int SW    = PHASE_W + FRAC_W;
    localparam int QW    = PHASE_W - 2;
    localparam int HALFQ = 1 << (QW - 1);

    logic        [PHASE_W-1:0] derot;
    logic        [PHASE_W-1:0] diff;
    logic        [PHASE_W-1:0] biased;
    logic signed [SW-1:0]      err_ext;
    logic signed [SW-1:0]      err_a;
    logic signed [SW-1:0]      err_b;

    always_comb begin
        derot   = samp_i + (odd_i ? PHASE_W'(HALFQ) : '0);
        diff    = derot - phase_i[SW-1:FRAC_W];
        biased  = diff + PHASE_W'(HALFQ);
        quad_o  = biased[PHASE_W-1:PHASE_W-2];
        err_ext = $signed({{(SW-QW){diff[QW-1]}}, diff[QW-1:0]}) <<< FRAC_W;
        err_a   = err_ext >>> KA;
        err_b   = err_ext >>> KB;
        freq_o  = freq_i + err_b;
        phase_o = phase_i + freq_o + err_a;
    end

endmodule

// File: rtl/cr_word_store.sv
module cr_word_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 30
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // R6/R7: writes land inside the store
    p_wr_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/cr_diff_decoder.sv
module cr_diff_decoder
    import cr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  step,
    input  quad_t quad_i,
    output quad_t dibit_o
);
    quad_t prev_q;

    always_ff @(posedge clk) begin
        if (rst || clear) prev_q <= '0;
        else if (step)    prev_q <= quad_i;
    end

    assign dibit_o = step_to_dibit(quad_i - prev_q);

endmodule

// File: rtl/cr_carrier_track.sv
module cr_carrier_track
    import cr_pkg::*;
#(
    parameter int PHASE_W      = 8,
    parameter int FRAC_W       = 4,
    parameter int BURST_LEN    = 60,
    parameter int CONV_LEN     = 30,
    parameter int GAIN_A_SHIFT = 1,
    parameter int GAIN_B_SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [PHASE_W+FRAC_W-1:0] freq_init,
    input  logic                      sym_valid,
    input  logic [PHASE_W-1:0]        sym_phase,
    output logic                      dibit_valid,
    output logic [1:0]                dibit,
    output logic                      burst_done
);
    localparam int             SW        = PHASE_W + FRAC_W;
    localparam int             CW        = $clog2(BURST_LEN);
    localparam int             AWC       = $clog2(CONV_LEN);
    localparam logic [CW-1:0]  LAST      = CW'(BURST_LEN - 1);
    localparam logic [CW-1:0]  CONV_LAST = CW'(CONV_LEN - 1);

    trk_state_e         st;
    logic [CW-1:0]      cnt;
    logic signed [SW-1:0] ph_q, fr_q;

    logic               fwd_take, back_step, out_step;
    logic [CW-1:0]      idx;
    logic signed [SW-1:0] ph_in, fr_in, ph_n, fr_n;
    logic [PHASE_W-1:0] samp, sym_rd;
    quad_t              quad_n, quad_rd, dec_dibit;
    out_beat_t          beat;

    assign fwd_take  = sym_valid && (start || st == ST_FWD);
    assign back_step = !start && st == ST_BACK;
    assign out_step  = !start && st == ST_OUT;
    assign idx       = start ? '0 : cnt;
    assign ph_in     = start ? '0 : ph_q;
    assign fr_in     = start ? $signed(freq_init) : fr_q;
    assign samp      = back_step ? sym_rd : sym_phase;

    cr_loop_core #(
        .PHASE_W(PHASE_W), .FRAC_W(FRAC_W),
        .KA(GAIN_A_SHIFT), .KB(GAIN_B_SHIFT)
    ) u_core (
        .phase_i(ph_in), .freq_i(fr_in), .samp_i(samp), .odd_i(idx[0]),
        .phase_o(ph_n), .freq_o(fr_n), .quad_o(quad_n)
    );

    // Early samples kept for the backward pass
    cr_word_store #(.WIDTH(PHASE_W), .DEPTH(CONV_LEN)) u_early (
        .clk(clk), .rst(rst),
        .we(fwd_take && (int'(idx) < CONV_LEN)),
        .waddr(idx[AWC-1:0]), .wdata(sym_phase),
        .raddr(cnt[AWC-1:0]), .rdata(sym_rd)
    );

    // Decided quadrants, indexed by arrival position
    cr_word_store #(.WIDTH(2), .DEPTH(BURST_LEN)) u_reorder (
        .clk(clk), .rst(rst),
        .we(fwd_take || back_step),
        .waddr(idx), .wdata(quad_n),
        .raddr(cnt), .rdata(quad_rd)
    );

    cr_diff_decoder u_diff (
        .clk(clk), .rst(rst),
        .clear(back_step && cnt == '0),
        .step(out_step),
        .quad_i(quad_rd),
        .dibit_o(dec_dibit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            ph_q <= '0;
            fr_q <= '0;
        end else if (start) begin
            st <= ST_FWD;
            if (sym_valid) begin
                cnt  <= CW'(1);
                ph_q <= ph_n;
                fr_q <= fr_n;
            end else begin
                cnt  <= '0;
                ph_q <= '0;
                fr_q <= $signed(freq_init);
            end
        end else begin
            unique case (st)
                ST_FWD: begin
                    if (sym_valid) begin
                        ph_q <= ph_n;
                        if (cnt == LAST) begin
                            st   <= ST_BACK;
                            cnt  <= CONV_LAST;
                            fr_q <= -fr_n;
                        end else begin
                            cnt  <= cnt + 1'b1;
                            fr_q <= fr_n;
                        end
                    end
                end
                ST_BACK: begin
                    ph_q <= ph_n;
                    fr_q <= fr_n;
                    if (cnt == '0) st <= ST_OUT;
                    else           cnt <= cnt - 1'b1;
                end
                ST_OUT: begin
                    if (cnt == LAST) begin
                        st  <= ST_DONE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: ;
            endcase
        end
    end

    always_comb begin
        beat.valid = (st == ST_OUT);
        beat.dibit = beat.valid ? dec_dibit : '0;
        beat.done  = (st == ST_DONE);
    end

    assign dibit_valid = beat.valid;
    assign dibit       = beat.dibit;
    assign burst_done  = beat.done;

    // R2: a start without a sample reseeds the loop
    p_seed_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !sym_valid) |=> (ph_q == '0 && fr_q == $signed($past(freq_init))));

    // R6: turning around negates the forward frequency
    p_turn_negates_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FWD && sym_valid && !start && cnt == LAST)
            |=> (st == ST_BACK && fr_q == -$past(fr_n)));

    // R7: readout runs without holes until the end marker
    p_out_contig_r7: assert property (@(posedge clk) disable iff (rst)
        (dibit_valid && !start) |=> (dibit_valid || burst_done));

    // R9: end marker directly after a dibit, never twice in a row
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> $past(dibit_valid));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);

endmodule

// File: tb/cr_carrier_track_test.sv
`timescale 1ns/1ps
module cr_carrier_track_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] freq_init = '0;
    logic        sym_valid = 1'b0;
    logic [7:0]  sym_phase = '0;
    logic        dibit_valid;
    logic [1:0]  dibit;
    logic        burst_done;

    always #4 clk = ~clk;

    cr_carrier_track uut (
        .clk(clk), .rst(rst), .start(start), .freq_init(freq_init),
        .sym_valid(sym_valid), .sym_phase(sym_phase),
        .dibit_valid(dibit_valid), .dibit(dibit), .burst_done(burst_done)
    );

    int n_chk = 0, n_fail = 0;
    int rng = 12345;
    logic [7:0] xs [60];
    int dexp [60];
    int dtx  [60];
    int got  [60];

    function int nxt();
        rng = rng * 1103515245 + 12345;
        return (rng >>> 16) & 32767;
    endfunction

    function automatic int wrap12s(int v);
        int w;
        w = v & 4095;
        if (w >= 2048) w -= 4096;
        return w;
    endfunction

    function automatic int gray(int dq);
        case (dq & 3)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int ungray(int d);
        case (d & 3)
            0: return 0;
            1: return 1;
            3: return 2;
            default: return 3;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample pattern: chosen dibits, phase offset p0, drift f per sample, noise +/-nz
    task automatic gen(input int p0, input int f, input int nz);
        int qp, qt, nv;
        qp = 0;
        for (int k = 0; k < 60; k++) begin
            dtx[k] = nxt() & 3;
            qt = (qp + ungray(dtx[k])) & 3;
            qp = qt;
            nv = (nz > 0) ? (nxt() % (2 * nz + 1)) - nz : 0;
            xs[k] = 8'((64 * qt - 32 * (k % 2) + p0 + f * k + nv) & 255);
        end
    endtask

    // Loop arithmetic per R3, R4, R5, R6, R8
    task automatic build_expect(input int fi);
        int ph, fr, y, d, e, prev;
        int q [60];
        ph = 0;
        fr = wrap12s(fi);
        for (int k = 0; k < 60; k++) begin
            y = (int'(xs[k]) + (k % 2) * 32) & 255;
            d = (y - (ph >> 4)) & 255;
            q[k] = ((d + 32) & 255) >> 6;
            e = d & 63;
            if (e >= 32) e -= 64;
            fr = wrap12s(fr + e);
            ph = (ph + fr + 8 * e) & 4095;
        end
        fr = wrap12s(-fr);
        for (int k = 29; k >= 0; k--) begin
            y = (int'(xs[k]) + (k % 2) * 32) & 255;
            d = (y - (ph >> 4)) & 255;
            q[k] = ((d + 32) & 255) >> 6;
            e = d & 63;
            if (e >= 32) e -= 64;
            fr = wrap12s(fr + e);
            ph = (ph + fr + 8 * e) & 4095;
        end
        prev = 0;
        for (int k = 0; k < 60; k++) begin
            dexp[k] = gray(q[k] - prev);
            prev = q[k];
        end
    endtask

    task automatic drive_syms(input int from, input int upto, input bit gaps);
        for (int k = from; k < upto; k++) begin
            if (gaps && (k % 7 == 3)) begin
                sym_valid = 1'b0;
                @(negedge clk);
            end
            sym_valid = 1'b1;
            sym_phase = xs[k];
            @(negedge clk);
        end
        sym_valid = 1'b0;
    endtask

    task automatic run_burst(input int fi, input bit with_first, input bit junk,
                             input bit gaps, input bit cmp_tx);
        int n, first_t, last_t, done_t;
        build_expect(fi);
        @(negedge clk);
        start = 1'b1;
        freq_init = 12'(fi);
        sym_valid = with_first;
        sym_phase = xs[0];
        @(negedge clk);
        start = 1'b0;
        drive_syms(with_first ? 1 : 0, 60, gaps);
        n = 0; first_t = -1; last_t = -1; done_t = -1;
        for (int t = 1; t < 130; t++) begin
            if (dibit_valid) begin
                if (n == 0) first_t = t;
                if (n < 60) got[n] = int'(dibit);
                n++;
                last_t = t;
            end
            if (burst_done) begin
                done_t = t;
                break;
            end
            sym_valid = junk;              // R10 stray samples
            sym_phase = 8'((t * 37) & 255);
            @(negedge clk);
        end
        sym_valid = 1'b0;
        chk(n == 60, "R7 dibit count", n, 60);
        chk(first_t == 31, "R7 first dibit latency", first_t, 31);
        chk(done_t == 91 && done_t == last_t + 1, "R9 done after last dibit", done_t, 91);
        for (int k = 0; k < 60 && k < n; k++) begin
            if (k < 30) chk(got[k] == dexp[k], "R6 backward-decided dibit", got[k], dexp[k]);
            else        chk(got[k] == dexp[k], "R5 forward-decided dibit", got[k], dexp[k]);
            if (cmp_tx) chk(got[k] == dtx[k], "R3 R8 clean dibit", got[k], dtx[k]);
        end
        @(negedge clk);
        chk(!burst_done && !dibit_valid, "R9 single done pulse", int'(burst_done), 0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int idle_bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset, stray samples ignored
        chk(!dibit_valid && !burst_done, "R1 reset outputs", int'(dibit_valid), 0);
        idle_bad = 0;
        for (int t = 0; t < 80; t++) begin
            sym_valid = 1'b1;
            sym_phase = 8'(t * 11);
            @(negedge clk);
            if (dibit_valid || burst_done) idle_bad++;
        end
        sym_valid = 1'b0;
        chk(idle_bad == 0, "R1 idle samples ignored", idle_bad, 0);

        // Clean constellation, no offsets: dibits equal the sent ones (R3, R8)
        gen(0, 0, 0);
        run_burst(0, 1'b0, 1'b0, 1'b0, 1'b1);

        // Phase-offset sweep with zero seed (R4, R5, R6)
        for (int p = 0; p < 256; p += 16) begin
            gen(p, 0, 2);
            run_burst(0, 1'b0, 1'b0, (p % 32) == 0, 1'b0);
        end

        // Drift with matched seed, mismatched seed, negative seed (R4)
        gen(5, 3, 0);
        run_burst(3 * 16, 1'b0, 1'b0, 1'b0, 1'b0);
        gen(40, 2, 3);
        run_burst(0, 1'b0, 1'b0, 1'b1, 1'b0);
        gen(200, -2, 1);
        run_burst(-40, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: stray samples during the backward pass and readout
        gen(17, 1, 2);
        run_burst(16, 1'b0, 1'b1, 1'b0, 1'b0);

        // R2: abort a half-received burst; start carries sample 0 of the next
        gen(90, 1, 0);
        @(negedge clk);
        start = 1'b1;
        freq_init = 12'(20);
        sym_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        drive_syms(0, 20, 1'b0);
        gen(33, -1, 2);
        run_burst(-16, 1'b1, 1'b0, 1'b1, 1'b0);

        // R2: seed and sample together, clean pattern
        gen(0, 0, 0);
        run_burst(0, 1'b1, 1'b1, 1'b0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule